// File: doc/BRIEF.md
# CAN-FD Transmit Frame Staging Bank

This block is the host-facing staging area of a CAN controller's transmit path. A host builds one outgoing frame at a time through a small write-only register window. It writes the payload words first, then the control word that holds the length code and the frame flags, and last the identifier. Only the identifier write hands the staged frame over. The frame is then copied, as one unit, into a transmit queue of parameterised depth. The protocol engine downstream drains that queue through a valid/ready port.

The staged control word decides how many payload words are kept. A classic frame always carries two words. An extended-length (FD) frame carries between two and sixteen words, chosen by its length code. Words past the frame's length are zeroed in the queued entry, so a short frame never carries bytes left over from a longer one. If the queue is full when a frame is handed over, that frame is lost and a sticky overflow indication is raised. The host clears that indication by writing one to it. The fill count and the full flag are available as outputs.

A two-state sequencer controls the commit. **STAGE** is the idle state, in which the registers take writes. An identifier write moves it to **PUSH** (transition *id_written*). In PUSH the latched frame is written into the queue, or dropped, during that one cycle. From PUSH the sequencer returns to STAGE (transition *pushed*), or stays in PUSH when another identifier write arrives in the same cycle (transition *back_to_back*).

Top module: `can_tx_stage`

## Requirements
- R1: A write to a payload, control, status or unmapped address never adds an entry to the queue: `fill_count` and `tx_valid` stay unchanged apart from downstream pops.
- R2: A write to the identifier address 0x0C0 commits the staged frame. If the write is sampled at clock edge k, the entry is counted and `tx_valid` rises after edge k+1.
- R3: Payload word 0 is at address 0x0C8 and word 1 is at 0x0CC. Words 2 to 15 are at 0x108 + 4·(n−2), which ends at 0x13C. The control word is at 0x0C4.
- R4: When control bit 30 (the FD flag) is clear, the entry carries 2 words (`tx_words` = 2), whatever the length code in bits [3:0].
- R5: When bit 30 is set, the word count follows the length code in bits [3:0]: codes 0–8 give 2 words, 9 gives 3, 10 gives 4, 11 gives 5, 12 gives 6, 13 gives 8, 14 gives 12 and 15 gives 16.
- R6: Payload words at or beyond the word count read as zero in the queued entry. Words below it carry the staged values; word n sits at `tx_data[32n+31:32n]`.
- R7: When bit 30 is set, bit 4 (remote request) is cleared in the queued control word. Otherwise the control word, including bits 4, 24 (single shot) and 29 (rate switch), is queued exactly as written.
- R8: A commit while `queue_full` is high drops the frame and sets `overflow`. `overflow` stays set until a write of 1 to bit 0 at address 0x0D0; writing 0 there has no effect.
- R9: Entries leave in commit order. An entry is removed when `tx_valid` and `tx_ready` are both high at an edge, and the output entry holds while it is not accepted. `fill_count` never exceeds DEPTH, and `queue_full` is high exactly when it equals DEPTH.
- R10: After reset the queue is empty (`tx_valid` = 0, `fill_count` = 0), `queue_full` is 0, `overflow` is 0 and all staged registers are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| tx_valid | output | 1 | Head-of-queue entry is available |
| tx_ready | input | 1 | Downstream accepts the head entry |
| tx_id | output | 32 | Identifier of the head entry |
| tx_ctrl | output | 32 | Control word of the head entry |
| tx_words | output | 5 | Number of payload words in the head entry |
| tx_data | output | 512 | Sixteen payload words, word n at bits 32n+31:32n |
| fill_count | output | CNT_W | Entries currently queued |
| queue_full | output | 1 | Queue holds DEPTH entries |
| overflow | output | 1 | Sticky flag: a commit was dropped |

## Verification
The properties assume the host makes at most one write per cycle and uses addresses that are word-aligned. They also assume the downstream side drops `tx_ready` only on its own clock schedule, never in the same cycle as a transfer. The stimulus keeps to these assumptions. Every write lasts exactly one cycle and is set up on the falling edge. `tx_ready` changes only on falling edges. While the queue is filled up to overflow, `tx_ready` is held low, so that push and pop never meet in the full case.

// File: rtl/can_txs_pkg.sv
package can_txs_pkg;

    localparam int WORD_W  = 32;
    localparam int NWORDS  = 16;
    localparam int WCNT_W  = 5;
    localparam int DATA_W  = NWORDS * WORD_W;

    // host address map (byte offsets)
    localparam logic [11:0] OFF_ID      = 12'h0C0;
    localparam logic [11:0] OFF_CTRL    = 12'h0C4;
    localparam logic [11:0] OFF_DATA_LO = 12'h0C8;
    localparam logic [11:0] OFF_STATUS  = 12'h0D0;
    localparam logic [11:0] OFF_DATA_HI = 12'h108;
    localparam int          HI_FIRST    = 2;

    // control word bit positions
    localparam int CB_RTR    = 4;
    localparam int CB_SINGLE = 24;
    localparam int CB_BRS    = 29;
    localparam int CB_FD     = 30;

    typedef enum logic {
        ST_STAGE = 1'b0,
        ST_PUSH  = 1'b1
    } stage_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] id;
        logic [WORD_W-1:0] ctrl;
        logic [WCNT_W-1:0] words;
        logic [DATA_W-1:0] data;
    } tx_entry_t;

endpackage

// File: rtl/can_txs_len_decode.sv
module can_txs_len_decode
    import can_txs_pkg::*;
(
    input  logic [3:0]        dlc,
    input  logic              fd,
    output logic [WCNT_W-1:0] words,
    output logic [NWORDS-1:0] word_mask
);

    always_comb begin
        words = WCNT_W'(2);
        if (fd) begin
            unique case (dlc)
                4'd9:    words = WCNT_W'(3);
                4'd10:   words = WCNT_W'(4);
                4'd11:   words = WCNT_W'(5);
                4'd12:   words = WCNT_W'(6);
                4'd13:   words = WCNT_W'(8);
                4'd14:   words = WCNT_W'(12);
                4'd15:   words = WCNT_W'(16);
                default: words = WCNT_W'(2);
            endcase
        end
    end

    for (genvar g = 0; g < NWORDS; g++) begin : g_mask
        assign word_mask[g] = (WCNT_W'(g) < words);
    end

endmodule

// File: rtl/can_txs_queue.sv
module can_txs_queue #(
    parameter  int DEPTH = 4,
    parameter  int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= nxt(wptr);
            if (do_pop)  rptr <= nxt(rptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (do_push) begin
            mem[wptr] <= push_data;
        end
    end

endmodule

// File: rtl/can_tx_stage.sv
module can_tx_stage
    import can_txs_pkg::*;
#(
    parameter  int DEPTH  = 4,
    parameter  int ADDR_W = 12,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [31:0]       tx_id,
    output logic [31:0]       tx_ctrl,
    output logic [4:0]        tx_words,
    output logic [DATA_W-1:0] tx_data,
    output logic [CNT_W-1:0]  fill_count,
    output logic              queue_full,
    output logic              overflow
);

    localparam int ENTRY_W = $bits(tx_entry_t);
    localparam int HI_SPAN = (NWORDS - HI_FIRST - 1) * 4;

    // ---------------- address decode ----------------
    logic              id_wr, ctrl_wr, stat_wr, data_wr;
    logic [3:0]        data_idx;
    logic [ADDR_W-1:0] hi_rel;

    assign hi_rel  = wr_addr - ADDR_W'(OFF_DATA_HI);
    assign id_wr   = wr_en && (wr_addr == ADDR_W'(OFF_ID));
    assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(OFF_CTRL));
    assign stat_wr = wr_en && (wr_addr == ADDR_W'(OFF_STATUS));

    always_comb begin
        data_wr  = 1'b0;
        data_idx = '0;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(OFF_DATA_LO)) begin
                data_wr  = 1'b1;
                data_idx = 4'd0;
            end else if (wr_addr == ADDR_W'(OFF_DATA_LO) + ADDR_W'(4)) begin
                data_wr  = 1'b1;
                data_idx = 4'd1;
            end else if (wr_addr >= ADDR_W'(OFF_DATA_HI) &&
                         hi_rel <= ADDR_W'(HI_SPAN) && wr_addr[1:0] == 2'b00) begin
                data_wr  = 1'b1;
                data_idx = 4'(hi_rel >> 2) + 4'(HI_FIRST);
            end
        end
    end

    // ---------------- staging registers ----------------
    logic [31:0] id_q, ctrl_q;
    logic [31:0] data_q [NWORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q   <= '0;
            ctrl_q <= '0;
            for (int i = 0; i < NWORDS; i++) data_q[i] <= '0;
        end else begin
            if (id_wr)   id_q   <= wr_data;
            if (ctrl_wr) ctrl_q <= wr_data;
            if (data_wr) data_q[data_idx] <= wr_data;
        end
    end

    // ---------------- commit sequencer ----------------
    stage_state_e state_q, state_d;
    logic         commit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STAGE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            ST_STAGE: begin
                if (id_wr) state_d = ST_PUSH;          // id_written
            end
            ST_PUSH: begin
                commit  = 1'b1;
                state_d = id_wr ? ST_PUSH : ST_STAGE;  // back_to_back / pushed
            end
            default: state_d = ST_STAGE;
        endcase
    end

    // ---------------- entry formation ----------------
    logic [WCNT_W-1:0] len_words;
    logic [NWORDS-1:0] len_mask;
    tx_entry_t         new_entry, head_entry;
    logic [31:0]       ctrl_eff;

    can_txs_len_decode u_len (
        .dlc       (ctrl_q[3:0]),
        .fd        (ctrl_q[CB_FD]),
        .words     (len_words),
        .word_mask (len_mask)
    );

    always_comb begin
        ctrl_eff = ctrl_q;
        if (ctrl_q[CB_FD]) ctrl_eff[CB_RTR] = 1'b0;
    end

    assign new_entry.id    = id_q;
    assign new_entry.ctrl  = ctrl_eff;
    assign new_entry.words = len_words;

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        assign new_entry.data[g*WORD_W +: WORD_W] = len_mask[g] ? data_q[g] : '0;
    end

    // ---------------- queue ----------------
    logic q_empty;

    can_txs_queue #(.DEPTH(DEPTH), .W(ENTRY_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (commit),
        .push_data (new_entry),
        .pop       (tx_ready),
        .head      (head_entry),
        .count     (fill_count),
        .full      (queue_full),
        .empty     (q_empty)
    );

    assign tx_valid = !q_empty;
    assign tx_id    = head_entry.id;
    assign tx_ctrl  = head_entry.ctrl;
    assign tx_words = head_entry.words;
    assign tx_data  = head_entry.data;

    // ---------------- sticky overflow ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          overflow <= 1'b0;
        else if (commit && queue_full)       overflow <= 1'b1;
        else if (stat_wr && wr_data[0])      overflow <= 1'b0;
    end

endmodule

// File: rtl/can_tx_stage_chk.sv
module can_tx_stage_chk
    import can_txs_pkg::*;
#(
    parameter  int DEPTH  = 4,
    parameter  int ADDR_W = 12,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic              commit,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [31:0]       tx_ctrl,
    input logic [4:0]        tx_words,
    input logic [DATA_W-1:0] tx_data,
    input logic [CNT_W-1:0]  fill_count,
    input logic              queue_full,
    input logic              overflow
);

    logic popping, clearing;
    assign popping  = tx_valid && tx_ready;
    assign clearing = wr_en && (wr_addr == ADDR_W'(OFF_STATUS)) && wr_data[0];

    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CNT_W'(DEPTH));

    // R1
    no_commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit && !popping |=> $stable(fill_count));

    // R2
    commit_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit && !queue_full && !popping |=> fill_count == CNT_W'($past(fill_count) + 1'b1));

    // R8
    drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit && queue_full |=> overflow);

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !clearing |=> overflow);

    // R7
    fd_rtr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ctrl[CB_FD] |-> !tx_ctrl[CB_RTR]);

    // R4
    classic_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ctrl[CB_FD] |-> (tx_words == 5'd2) && (tx_data[DATA_W-1:64] == '0));

    // R9
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_ctrl));

endmodule

bind can_tx_stage can_tx_stage_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_can_tx_stage.sv
module tb_can_tx_stage;

    localparam int DEPTH  = 4;
    localparam int ADDR_W = 12;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic              tx_valid;
    logic              tx_ready = 1'b0;
    logic [31:0]       tx_id, tx_ctrl;
    logic [4:0]        tx_words;
    logic [511:0]      tx_data;
    logic [CNT_W-1:0]  fill_count;
    logic              queue_full, overflow;

    always #10 clk = ~clk;

    can_tx_stage #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_id(tx_id), .tx_ctrl(tx_ctrl),
        .tx_words(tx_words), .tx_data(tx_data), .fill_count(fill_count),
        .queue_full(queue_full), .overflow(overflow)
    );

    typedef struct {
        logic [31:0]  id;
        logic [31:0]  ctrl;
        logic [4:0]   words;
        logic [511:0] data;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] data_addr(input int n);
        return (n < 2) ? 12'(12'h0C8 + 4 * n) : 12'(12'h108 + 4 * (n - 2));
    endfunction

    function automatic logic [4:0] exp_words(input logic [31:0] c);
        if (!c[30]) return 5'd2;
        case (c[3:0])
            4'd9:  return 5'd3;
            4'd10: return 5'd4;
            4'd11: return 5'd5;
            4'd12: return 5'd6;
            4'd13: return 5'd8;
            4'd14: return 5'd12;
            4'd15: return 5'd16;
            default: return 5'd2;
        endcase
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] pat(input logic [31:0] id, input int n);
        return 32'hD000_0000 | (id << 8) | 32'(n);
    endfunction

    task automatic stage_body(input logic [31:0] id, input logic [31:0] ctrl);
        for (int n = 0; n < 16; n++) wr(data_addr(n), pat(id, n));
        wr(12'h0C4, ctrl);
    endtask

    task automatic expect_frame(input logic [31:0] id, input logic [31:0] ctrl);
        exp_t e;
        e.id    = id;
        e.ctrl  = ctrl;
        if (ctrl[30]) e.ctrl[4] = 1'b0;
        e.words = exp_words(ctrl);
        e.data  = '0;
        for (int n = 0; n < 16; n++)
            if (n < int'(e.words)) e.data[n*32 +: 32] = pat(id, n);
        sb.push_back(e);
    endtask

    task automatic send(input logic [31:0] id, input logic [31:0] ctrl, input bit accept);
        stage_body(id, ctrl);
        if (accept) expect_frame(id, ctrl);
        wr(12'h0C0, id);
        repeat (2) @(negedge clk);
    endtask

    // monitor: compares every transfer with the scoreboard head
    always @(negedge clk) begin
        #1;
        if (rst_n && tx_valid && tx_ready) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R9 unexpected entry", 512'(tx_id), 512'(0));
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(tx_id == e.id,       "R9 order/id",     512'(tx_id),    512'(e.id));
                chk(tx_ctrl == e.ctrl,   "R7 ctrl",         512'(tx_ctrl),  512'(e.ctrl));
                chk(tx_words == e.words, "R5 R4 words",     512'(tx_words), 512'(e.words));
                chk(tx_data == e.data,   "R3 R6 data",      tx_data,        e.data);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R10
        chk(!tx_valid,          "R10 valid",    512'(tx_valid),   512'(0));
        chk(fill_count == 0,    "R10 count",    512'(fill_count), 512'(0));
        chk(!queue_full,        "R10 full",     512'(queue_full), 512'(0));
        chk(!overflow,          "R10 overflow", 512'(overflow),   512'(0));

        // R1: payload, control, status and unmapped writes only
        stage_body(32'h77, 32'h4000_000F);
        wr(12'h0D0, 32'h0);
        wr(12'h100, 32'hFFFF_FFFF);
        repeat (3) @(negedge clk); #1;
        chk(fill_count == 0, "R1 count", 512'(fill_count), 512'(0));
        chk(!tx_valid,       "R1 valid", 512'(tx_valid),   512'(0));

        // fill the queue while the consumer is stalled
        send(32'h101, 32'h0000_0018, 1'b1);                  // classic, RTR kept
        send(32'h202, 32'h6000_0009, 1'b1);                  // FD + rate switch, 3 words
        send(32'h303, 32'h4100_001D, 1'b1);                  // FD, RTR dropped, single shot, 8 words
        send(32'h404, 32'h4000_000F, 1'b1);                  // FD, 16 words
        #1;
        chk(fill_count == 4, "R9 count full", 512'(fill_count), 512'(4));
        chk(queue_full,      "R9 full flag",  512'(queue_full), 512'(1));
        chk(!overflow,       "R8 no overflow yet", 512'(overflow), 512'(0));

        send(32'h505, 32'h4000_000E, 1'b0);                  // dropped
        #1;
        chk(overflow,        "R8 overflow set",   512'(overflow),   512'(1));
        chk(fill_count == 4, "R8 count unchanged", 512'(fill_count), 512'(4));
        wr(12'h0D0, 32'h0);
        #1;
        chk(overflow,        "R8 write 0 keeps",  512'(overflow),   512'(1));
        wr(12'h0D0, 32'h1);
        #1;
        chk(!overflow,       "R8 write 1 clears", 512'(overflow),   512'(0));

        // drain in order
        @(negedge clk); tx_ready = 1'b1;
        repeat (8) @(negedge clk); #1;
        chk(fill_count == 0, "R9 drained", 512'(fill_count), 512'(0));

        // sweep every length code, classic and FD
        for (int fd = 0; fd < 2; fd++) begin
            for (int d = 0; d < 16; d++) begin
                send(32'h600 + 32'(fd * 16 + d), (fd != 0 ? 32'h4000_0000 : 32'h0) | 32'(d), 1'b1);
            end
        end
        repeat (4) @(negedge clk);

        // R2 commit timing
        @(negedge clk); tx_ready = 1'b0;
        stage_body(32'h7AB, 32'h4000_000B);
        expect_frame(32'h7AB, 32'h4000_000B);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 12'h0C0; wr_data = 32'h7AB;
        @(negedge clk);
        wr_en = 1'b0; #1;
        chk(!tx_valid, "R2 not yet after one edge", 512'(tx_valid), 512'(0));
        @(negedge clk); #1;
        chk(tx_valid,        "R2 valid after second edge", 512'(tx_valid),   512'(1));
        chk(fill_count == 1, "R2 count",                   512'(fill_count), 512'(1));
        @(negedge clk); tx_ready = 1'b1;
        repeat (4) @(negedge clk); #1;

        chk(sb.size() == 0, "R9 all frames seen", 512'(sb.size()), 512'(0));
        chk(fill_count == 0, "R9 empty at end",   512'(fill_count), 512'(0));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule